// File: doc/BRIEF.md
# Prescaled Interval Timer Bank

The block holds a group of identical 16-bit up-counters, each behind a small word-addressed register window. Every channel picks one of two shared tick-enable inputs as its time base. It can divide that tick by a power of two before counting. It runs either free (wrapping through zero) or in interval mode, where it returns to zero on reaching a programmed limit and raises a status flag. Software arms a channel by writing its configuration words. It collects events by reading the status word, and that read also acknowledges them. Each channel drives its own level interrupt line.

All register reads are combinational from the current state. Writes and the clear caused by a status read take effect on the next rising clock edge. Channel c's registers sit at the base offsets listed below plus 4·c.

Top module: `tmr_bank`

## Requirements
- R1: After reset every channel reads counter-control = 0x1 (halted) and zero in all other registers, and every interrupt line is low.
- R2: Channel c decodes clock-config at 0x00+4c (bits 5:0), counter-control at 0x0C+4c (bits 1:0), count at 0x18+4c (read only), limit at 0x24+4c (bits 15:0), status at 0x54+4c (bit 0, read only) and interrupt mask at 0x60+4c (bit 0). Unwritten bits read 0, writes to read-only words are ignored, and any other address reads 0.
- R3: With counter-control bit 1 clear, the count rises by one per advance and wraps from 0xFFFF to 0 without setting status.
- R4: Clock-config bit 5 chooses the time base: 0 takes tick_a, 1 takes tick_b. Ticks on the other input have no effect.
- R5: Clock-config bit 0 turns the divider on and bits 4:1 hold N. When the divider is on, the count advances once per 2^(N+1) selected ticks, and the divider restarts after each advance. When it is off, the divider is held at zero and every selected tick advances the count.
- R6: While counter-control bit 0 is set, neither the count nor the divider moves.
- R7: Writing counter-control with bit 4 set loads zero into the count and the divider on that write's clock edge, with no advance in that cycle. Bit 4 always reads back 0.
- R8: With counter-control bit 1 set, an advance taken while the count equals the limit returns the count to 0 and sets status bit 0.
- R9: A read of a channel's status word returns the flag and clears it on the same edge. A flag set on that same edge stays set.
- R10: A channel's interrupt output is high exactly while its status bit 0 and mask bit 0 are both 1.
- R11: Channels are independent: accesses and ticks aimed at one channel leave the others' registers and interrupts unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_a | input | 1 | Time-base enable, source 0 |
| tick_b | input | 1 | Time-base enable, source 1 |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (only status reads have a side effect) |
| bus_addr | input | ADDR_W (8) | Byte address of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational |
| irq | output | NUM_CH (3) | Per-channel level interrupt |

## Verification
The bench uses the default parameters: three channels, 16-bit counters, 8-bit addresses and a 4-bit exponent field. With 16-bit counters a full wrap takes 65,536 ticks, which fits in the run, so the 0xFFFF-to-0 rollover is driven for real. The 4-bit exponent lets the bench try divides of 2, 4 and 2048. Three channels are enough to check every address stride and the isolation between neighbours. A behavioural model of all three channels is compared against bus_rdata and irq on every cycle. This catches off-by-one edges in the divider, the interval limit and the clear-on-read race.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int EXP_W       = 4;
    localparam int CLK_BITS    = EXP_W + 2;
    localparam int CTL_BITS    = 2;
    localparam int CTL_RST_BIT = 4;

    localparam int OFF_CLK  = 'h00;
    localparam int OFF_CTL  = 'h0C;
    localparam int OFF_VAL  = 'h18;
    localparam int OFF_IVAL = 'h24;
    localparam int OFF_STAT = 'h54;
    localparam int OFF_IEN  = 'h60;
    localparam int STRIDE   = 4;

    typedef struct packed {
        logic             src_b;
        logic [EXP_W-1:0] pexp;
        logic             pre_on;
    } clk_cfg_t;

    typedef struct packed {
        logic ival_mode;
        logic halt;
    } ctl_cfg_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             enable,
    input  logic [EXP_W-1:0] pexp,
    input  logic             clear,
    output logic             adv
);
    localparam int DIV_W = (1 << EXP_W) + 1;

    typedef struct packed {
        logic [DIV_W-1:0] acc;
    } pre_state_t;

    pre_state_t       p_d, p_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        p_d = p_q;
        adv = 1'b0;
        lim = (DIV_W'(1) << (int'(pexp) + 1)) - DIV_W'(1);
        if (clear || !enable) begin
            p_d.acc = '0;
            adv     = !clear && !enable && run && tick;
        end else if (run && tick) begin
            if (p_q.acc >= lim) begin
                p_d.acc = '0;
                adv     = 1'b1;
            end else begin
                p_d.acc = p_q.acc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    AST_PRE_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && enable && !clear) |=> $stable(p_q.acc)); // R6

    AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (p_q.acc == '0)); // R7
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_a,
    input  logic                tick_b,
    input  logic                wr_clk,
    input  logic                wr_ctl,
    input  logic                wr_ival,
    input  logic                wr_ien,
    input  logic                st_rd,
    input  logic [CNT_W-1:0]    wdata,
    output logic [CLK_BITS-1:0] clk_word,
    output logic [CTL_BITS-1:0] ctl_word,
    output logic [CNT_W-1:0]    count,
    output logic [CNT_W-1:0]    limit,
    output logic                flag,
    output logic                ien,
    output logic                irq
);
    typedef struct packed {
        clk_cfg_t         ccfg;
        ctl_cfg_t         kcfg;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] ival;
        logic             flag;
        logic             ien;
    } ch_state_t;

    ch_state_t s_d, s_q;
    logic      tick_sel;
    logic      rst_cmd;
    logic      adv;
    logic      hit;

    assign tick_sel = s_q.ccfg.src_b ? tick_b : tick_a;
    assign rst_cmd  = wr_ctl & wdata[CTL_RST_BIT];

    tmr_prescale u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_sel),
        .run    (!s_q.kcfg.halt),
        .enable (s_q.ccfg.pre_on),
        .pexp   (s_q.ccfg.pexp),
        .clear  (rst_cmd),
        .adv    (adv)
    );

    always_comb begin
        s_d = s_q;
        hit = 1'b0;
        if (rst_cmd) begin
            s_d.cnt = '0;
        end else if (adv) begin
            if (s_q.kcfg.ival_mode && (s_q.cnt == s_q.ival)) begin
                s_d.cnt = '0;
                hit     = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
        s_d.flag = hit | (s_q.flag & ~st_rd);
        if (wr_clk)  s_d.ccfg = clk_cfg_t'(wdata[CLK_BITS-1:0]);
        if (wr_ctl)  s_d.kcfg = ctl_cfg_t'(wdata[CTL_BITS-1:0]);
        if (wr_ival) s_d.ival = wdata;
        if (wr_ien)  s_d.ien  = wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.kcfg.halt <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign clk_word = s_q.ccfg;
    assign ctl_word = s_q.kcfg;
    assign count    = s_q.cnt;
    assign limit    = s_q.ival;
    assign flag     = s_q.flag;
    assign ien      = s_q.ien;
    assign irq      = s_q.flag & s_q.ien;

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.kcfg.halt && !rst_cmd) |=> $stable(s_q.cnt)); // R6

    AST_RST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rst_cmd |=> (s_q.cnt == '0)); // R7

    AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !rst_cmd && !s_q.kcfg.ival_mode && (s_q.cnt == '1)) |=> (s_q.cnt == '0)); // R3

    AST_FLAG_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.flag) |-> $past(s_q.kcfg.ival_mode)); // R8

    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flag && !st_rd) |=> s_q.flag); // R9
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_a,
    input  logic              tick_b,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    logic [CLK_BITS-1:0] clk_w  [NUM_CH];
    logic [CTL_BITS-1:0] ctl_w  [NUM_CH];
    logic [CNT_W-1:0]    cnt_w  [NUM_CH];
    logic [CNT_W-1:0]    lim_w  [NUM_CH];
    logic [NUM_CH-1:0]   flag_v;
    logic [NUM_CH-1:0]   ien_v;
    logic                unused_wdata;

    assign unused_wdata = ^bus_wdata;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_CLK  = ADDR_W'(OFF_CLK  + STRIDE * g);
        localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFF_CTL  + STRIDE * g);
        localparam logic [ADDR_W-1:0] A_IVAL = ADDR_W'(OFF_IVAL + STRIDE * g);
        localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT + STRIDE * g);
        localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFF_IEN  + STRIDE * g);

        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_a   (tick_a),
            .tick_b   (tick_b),
            .wr_clk   (bus_wr && (bus_addr == A_CLK)),
            .wr_ctl   (bus_wr && (bus_addr == A_CTL)),
            .wr_ival  (bus_wr && (bus_addr == A_IVAL)),
            .wr_ien   (bus_wr && (bus_addr == A_IEN)),
            .st_rd    (bus_rd && (bus_addr == A_STAT)),
            .wdata    (bus_wdata[CNT_W-1:0]),
            .clk_word (clk_w[g]),
            .ctl_word (ctl_w[g]),
            .count    (cnt_w[g]),
            .limit    (lim_w[g]),
            .flag     (flag_v[g]),
            .ien      (ien_v[g]),
            .irq      (irq[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr == ADDR_W'(OFF_CLK + STRIDE * c))  bus_rdata = DATA_W'(clk_w[c]);
            if (bus_addr == ADDR_W'(OFF_CTL + STRIDE * c))  bus_rdata = DATA_W'(ctl_w[c]);
            if (bus_addr == ADDR_W'(OFF_VAL + STRIDE * c))  bus_rdata = DATA_W'(cnt_w[c]);
            if (bus_addr == ADDR_W'(OFF_IVAL + STRIDE * c)) bus_rdata = DATA_W'(lim_w[c]);
            if (bus_addr == ADDR_W'(OFF_STAT + STRIDE * c)) bus_rdata = DATA_W'(flag_v[c]);
            if (bus_addr == ADDR_W'(OFF_IEN + STRIDE * c))  bus_rdata = DATA_W'(ien_v[c]);
        end
    end

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[0]) |-> (flag_v[0] && ien_v[0])); // R10
endmodule

// File: tb/tb_tmr_bank.sv
module tb_tmr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ta = 1'b0, tb = 1'b0;
    logic        wr_i = 1'b0, rd_i = 1'b0;
    logic [7:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata;
    logic [2:0]  irq;

    int    n_vec = 0, n_bad = 0, n_cyc = 0;
    bit    chk_on = 1'b0;
    string phase = "R1";

    logic [31:0] m_clk [3];
    logic [31:0] m_ctl [3];
    logic [31:0] m_cnt [3];
    logic [31:0] m_iv  [3];
    logic [31:0] m_fl  [3];
    logic [31:0] m_ien [3];
    int          m_pre [3];

    always #10 clk = ~clk;

    tmr_bank dut (
        .clk(clk), .rst_n(rst_n), .tick_a(ta), .tick_b(tb),
        .bus_wr(wr_i), .bus_rd(rd_i), .bus_addr(addr_i), .bus_wdata(wdata_i),
        .bus_rdata(rdata), .irq(irq)
    );

    function automatic logic [31:0] m_read(input logic [7:0] a);
        logic [31:0] v = '0;
        for (int c = 0; c < 3; c++) begin
            if (a == 8'(8'h00 + 4*c)) v = m_clk[c];
            if (a == 8'(8'h0C + 4*c)) v = m_ctl[c];
            if (a == 8'(8'h18 + 4*c)) v = m_cnt[c];
            if (a == 8'(8'h24 + 4*c)) v = m_iv[c];
            if (a == 8'(8'h54 + 4*c)) v = m_fl[c];
            if (a == 8'(8'h60 + 4*c)) v = m_ien[c];
        end
        return v;
    endfunction

    function automatic logic [2:0] m_irq();
        logic [2:0] v;
        for (int c = 0; c < 3; c++) v[c] = m_fl[c][0] & m_ien[c][0];
        return v;
    endfunction

    // behavioural reference, one step per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 3; c++) begin
                m_clk[c] = 0; m_ctl[c] = 1; m_cnt[c] = 0;
                m_iv[c] = 0; m_fl[c] = 0; m_ien[c] = 0; m_pre[c] = 0;
            end
        end else begin
            for (int c = 0; c < 3; c++) begin
                bit src, rcmd, adv, hit, clr;
                int lim;
                src  = m_clk[c][5] ? tb : ta;
                rcmd = wr_i && addr_i == 8'(8'h0C + 4*c) && wdata_i[4];
                clr  = rd_i && addr_i == 8'(8'h54 + 4*c);
                adv  = 0;
                hit  = 0;
                if (rcmd) begin
                    m_cnt[c] = 0;
                    m_pre[c] = 0;
                end else if (!m_clk[c][0]) begin
                    m_pre[c] = 0;
                    adv = !m_ctl[c][0] && src;
                end else if (!m_ctl[c][0] && src) begin
                    lim = (1 << (int'(m_clk[c][4:1]) + 1)) - 1;
                    if (m_pre[c] >= lim) begin m_pre[c] = 0; adv = 1; end
                    else m_pre[c] = m_pre[c] + 1;
                end
                if (adv) begin
                    if (m_ctl[c][1] && m_cnt[c] == m_iv[c]) begin m_cnt[c] = 0; hit = 1; end
                    else m_cnt[c] = (m_cnt[c] + 1) & 32'hFFFF;
                end
                m_fl[c] = (hit || (m_fl[c][0] && !clr)) ? 1 : 0;
                if (wr_i && addr_i == 8'(8'h00 + 4*c)) m_clk[c] = wdata_i & 32'h3F;
                if (wr_i && addr_i == 8'(8'h0C + 4*c)) m_ctl[c] = wdata_i & 32'h3;
                if (wr_i && addr_i == 8'(8'h24 + 4*c)) m_iv[c]  = wdata_i & 32'hFFFF;
                if (wr_i && addr_i == 8'(8'h60 + 4*c)) m_ien[c] = wdata_i & 32'h1;
            end
        end
    end

    // per-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        if (chk_on) begin
            n_vec++;
            if (rdata !== m_read(addr_i)) begin
                n_bad++;
                $display("FAIL %s model rdata addr=%h actual=%h expected=%h", phase, addr_i, rdata, m_read(addr_i));
            end
            n_vec++;
            if (irq !== m_irq()) begin
                n_bad++;
                $display("FAIL R10 model irq actual=%b expected=%b", irq, m_irq());
            end
        end
    end

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 200000) begin
            n_bad++;
            $display("FAIL R11 watchdog actual=%0d cycles expected=below 200000", n_cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic cyc(input bit w, input bit r, input logic [7:0] a,
                       input logic [31:0] d, input bit xa, input bit xb);
        @(negedge clk);
        #1;
        wr_i = w; rd_i = r; addr_i = a; wdata_i = d; ta = xa; tb = xb;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(1, 0, a, d, 0, 0);
    endtask

    task automatic ticks(input int n, input bit xa, input bit xb);
        for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 0, xa, xb);
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        cyc(0, 1, a, 0, 0, 0);
        #4;
        n_vec++;
        if (rdata !== exp) begin
            n_bad++;
            $display("FAIL %s read addr=%h actual=%h expected=%h", tag, a, rdata, exp);
        end
    endtask

    task automatic irq_chk(input logic [2:0] exp, input string tag);
        cyc(0, 0, 8'h00, 0, 0, 0);
        #4;
        n_vec++;
        if (irq !== exp) begin
            n_bad++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
        end
    endtask

    initial begin
        ticks(3, 0, 0);
        @(negedge clk); #1 rst_n = 1'b1;
        @(negedge clk); #1 chk_on = 1'b1;

        phase = "R1";
        for (int c = 0; c < 3; c++) begin
            rd_chk(8'(8'h00 + 4*c), 0, "R1");
            rd_chk(8'(8'h0C + 4*c), 1, "R1");
            rd_chk(8'(8'h18 + 4*c), 0, "R1");
            rd_chk(8'(8'h24 + 4*c), 0, "R1");
            rd_chk(8'(8'h54 + 4*c), 0, "R1");
            rd_chk(8'(8'h60 + 4*c), 0, "R1");
        end
        irq_chk(3'b000, "R1");

        phase = "R2";
        wr(8'h04, 32'h3F);        rd_chk(8'h04, 32'h3F, "R2");
        wr(8'h04, 32'hFFFF_FFFF); rd_chk(8'h04, 32'h3F, "R2");
        wr(8'h04, 0);
        wr(8'h2C, 32'hABCD_1234); rd_chk(8'h2C, 32'h1234, "R2");
        wr(8'h1C, 32'h55);        rd_chk(8'h1C, 0, "R2");
        wr(8'h58, 32'h1);         rd_chk(8'h58, 0, "R2");
        wr(8'h64, 32'hFF);        rd_chk(8'h64, 1, "R2");
        wr(8'h64, 0);
        rd_chk(8'h70, 0, "R2");
        rd_chk(8'h02, 0, "R2");
        rd_chk(8'h6C, 0, "R2");

        phase = "R3";
        wr(8'h0C, 0);
        ticks(65539, 1, 0);
        rd_chk(8'h18, 3, "R3");
        rd_chk(8'h54, 0, "R3");
        wr(8'h0C, 1);

        phase = "R4";
        wr(8'h04, 32'h20);
        wr(8'h10, 32'h10);
        ticks(4, 1, 0);
        rd_chk(8'h1C, 0, "R4");
        ticks(3, 0, 1);
        rd_chk(8'h1C, 3, "R4");

        phase = "R5";
        wr(8'h08, 32'h03);
        wr(8'h14, 32'h10);
        ticks(9, 1, 0);
        rd_chk(8'h20, 2, "R5");
        wr(8'h08, 32'h01);
        wr(8'h14, 32'h10);
        ticks(6, 1, 0);
        rd_chk(8'h20, 3, "R5");
        wr(8'h08, 32'h15);
        wr(8'h14, 32'h10);
        ticks(4096, 1, 0);
        rd_chk(8'h20, 2, "R5");

        phase = "R6";
        wr(8'h14, 32'h01);
        ticks(10, 1, 0);
        rd_chk(8'h20, 2, "R6");

        phase = "R7";
        wr(8'h14, 32'h11);
        rd_chk(8'h20, 0, "R7");
        rd_chk(8'h14, 1, "R7");

        phase = "R8";
        wr(8'h24, 5);
        wr(8'h60, 1);
        wr(8'h0C, 32'h12);
        ticks(5, 1, 0);
        rd_chk(8'h18, 5, "R8");
        irq_chk(3'b000, "R8");
        ticks(1, 1, 0);
        rd_chk(8'h18, 0, "R8");
        irq_chk(3'b001, "R8");

        phase = "R9";
        rd_chk(8'h54, 1, "R9");
        rd_chk(8'h54, 0, "R9");
        irq_chk(3'b000, "R9");
        wr(8'h24, 0);
        cyc(0, 1, 8'h54, 0, 1, 0);
        rd_chk(8'h54, 1, "R9");

        phase = "R10";
        ticks(1, 1, 0);
        irq_chk(3'b001, "R10");
        wr(8'h60, 0);
        irq_chk(3'b000, "R10");
        rd_chk(8'h54, 1, "R10");
        irq_chk(3'b000, "R10");
        wr(8'h60, 1);

        phase = "R11";
        rd_chk(8'h1C, 3, "R11");
        rd_chk(8'h58, 0, "R11");
        rd_chk(8'h5C, 0, "R11");
        irq_chk(3'b000, "R11");

        ticks(2, 0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule